// File: doc/BRIEF.md
# Prioritized Nested Event Controller

This block gathers event requests from peripherals and from the core, places them on sixteen priority levels, and offers the service-routine start address of the most urgent eligible level to the instruction fetch stage. Levels 0 to 6 are fixed core events, which include emulation, reset, the non-maskable event, exceptions and the core timer. Levels 7 to 15 are general purpose. Each peripheral source has a programmable level assignment. Several sources may share a level. Software can raise levels 14 and 15 directly. Each level has a start address in a writable vector table.

The offer to the fetch stage is a valid/ready stream. `evt_valid` depends only on stored state and configuration. While it is low, `evt_ready` has no effect. The level and address on offer may change before acceptance, but only because a more urgent request arrived or the configuration was rewritten. The fetch stage may hold `evt_ready` low for as long as it needs; the request stays pending. Acceptance happens on any cycle with both signals high.

When an offer is accepted, the controller enters a hold in which no further event is offered, whatever its priority. The hold ends on the `ret_saved` strobe, which tells the controller the return address is safe, or on a return. After that, nesting follows the active-level record: an event is offered only if it is more urgent than every active level. When self-nesting is enabled, an event at the same level as the most urgent active routine is also offered, up to a depth of three.

Top module: `evt_ctrl_top`

## Requirements
- R1: Among the pending, unmasked levels, the offer always carries the lowest-numbered one. Level 0 is the most urgent and level 15 the least.
- R2: Each source has a 4-bit level field. Its reset value is 7 + (source index mod 9). A write below 7 is stored as 7. A source request raises the level held in its field. Sources sharing a level raise one pending bit.
- R3: `evt_addr` equals the vector-table entry for `evt_level`. A write with `tbl_we` stores `tbl_addr` at entry `tbl_lvl`.
- R4: Mask bit i set to 1 enables level i, and the mask resets to all zeros. A masked level stays pending and is offered once unmasked. Levels 1 (reset) and 2 (non-maskable) are offered regardless of the mask.
- R5: An acceptance clears the pending bit of the accepted level and marks that level active in `active_lvls` on the next cycle.
- R6: After an acceptance, `preempt_hold` is high and `evt_valid` stays low, even for more urgent levels, until `ret_saved` or `ret_strobe` is pulsed.
- R7: An event is offered only if its level is more urgent than every active level. An event at the same level as the most urgent active level is also offered when `self_nest_en` is 1 and that level's nesting depth is below 3.
- R8: A `ret_strobe` pulse lowers the nesting depth of the most urgent active level by one. The level leaves `active_lvls` when its depth reaches zero. With nothing active, the pulse has no effect.
- R9: `swi_raise[0]` raises level 14 and `swi_raise[1]` raises level 15.
- R10: After reset, nothing is pending or active, and `evt_valid` and `preempt_hold` are low.
- R11: `evt_ready` while `evt_valid` is low changes neither the active levels nor the hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| src_req | input | NUM_SRC | Peripheral request pulses |
| core_req | input | 7 | Requests for fixed levels 0..6 |
| swi_raise | input | 2 | Software raise of levels 14 and 15 |
| map_we | input | 1 | Source level field write |
| map_sel | input | SRC_W | Source selected for the write |
| map_lvl | input | 4 | New level for the source |
| mask_we | input | 1 | Mask register write |
| mask_val | input | 16 | New mask, 1 = enabled |
| tbl_we | input | 1 | Vector table write |
| tbl_lvl | input | 4 | Table entry written |
| tbl_addr | input | ADDR_W | Routine address written |
| self_nest_en | input | 1 | Allow same-level nesting |
| evt_valid | output | 1 | Offer to fetch stage is valid |
| evt_ready | input | 1 | Fetch stage accepts the offer |
| evt_level | output | 4 | Level on offer |
| evt_addr | output | ADDR_W | Routine address on offer |
| ret_strobe | input | 1 | Current routine returns |
| ret_saved | input | 1 | Return address has been saved |
| active_lvls | output | 16 | Levels with a routine in progress |
| preempt_hold | output | 1 | Entry hold in force |

## Verification
Each level is raised alone to check the offered level and its table address. Every pair of distinct levels is then raised together. The pairs separate correct priority ordering from a reversed or partial encoder, and show whether a less urgent pending level is correctly held back behind an active one until it returns. Directed sequences raise a more urgent event during the entry hold, which detects a hold that ends early. They also nest one level three deep, which exposes mistakes in the depth limit and the return counting. A masked sweep that also raises the reset and non-maskable levels shows which levels bypass the mask. Remapped and clamped sources, shared levels and the software raise bits complete the routing checks.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int LVLS     = 16;
  localparam int LW       = 4;
  localparam int GP_FIRST = 7;
  localparam int GP_COUNT = LVLS - GP_FIRST;
  localparam int RST_LVL  = 1;
  localparam int NMI_LVL  = 2;

  // Index of the lowest set bit, or LVLS when no bit is set.
  function automatic logic [LW:0] prio_pick(input logic [LVLS-1:0] v);
    logic [LW:0] r;
    r = (LW+1)'(LVLS);
    for (int i = LVLS - 1; i >= 0; i--)
      if (v[i]) r = (LW+1)'(i);
    return r;
  endfunction
endpackage

// File: rtl/evt_src_map.sv
module evt_src_map
  import evt_pkg::*;
#(
  parameter int NUM_SRC = 12,
  parameter int SRC_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               map_we,
  input  logic [SRC_W-1:0]   map_sel,
  input  logic [LW-1:0]      map_lvl,
  input  logic [NUM_SRC-1:0] src_req,
  output logic [LVLS-1:0]    lvl_req
);
  logic [NUM_SRC-1:0][LW-1:0] lvl_of;
  logic [LW-1:0]              wr_lvl;

  assign wr_lvl = (map_lvl < LW'(GP_FIRST)) ? LW'(GP_FIRST) : map_lvl;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic [LW-1:0] lvl_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lvl_q <= LW'(GP_FIRST + (s % GP_COUNT));
      else if (map_we && map_sel == SRC_W'(s))
        lvl_q <= wr_lvl;
    end
    assign lvl_of[s] = lvl_q;
  end

  always_comb begin
    lvl_req = '0;
    for (int s = 0; s < NUM_SRC; s++)
      if (src_req[s]) lvl_req[lvl_of[s]] = 1'b1;
  end
endmodule

// File: rtl/evt_pend_arb.sv
module evt_pend_arb
  import evt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LVLS-1:0] raise,
  input  logic            mask_we,
  input  logic [LVLS-1:0] mask_val,
  input  logic            clr_en,
  input  logic [LW-1:0]   clr_lvl,
  output logic [LW:0]     best
);
  localparam logic [LVLS-1:0] NO_MASK = (LVLS'(1) << RST_LVL) | (LVLS'(1) << NMI_LVL);

  logic [LVLS-1:0] pend_q, mask_q, clr_hot;

  assign clr_hot = clr_en ? (LVLS'(1) << clr_lvl) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_hot) | raise;
      if (mask_we) mask_q <= mask_val;
    end
  end

  assign best = prio_pick(pend_q & (mask_q | NO_MASK));
endmodule

// File: rtl/evt_nest_track.sv
module evt_nest_track
  import evt_pkg::*;
#(
  parameter int DEPTH_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic [LW-1:0]   take_lvl,
  input  logic            ret_strobe,
  input  logic            ret_saved,
  output logic [LVLS-1:0] active,
  output logic [LW:0]     top,
  output logic            top_full,
  output logic            hold
);
  logic [LVLS-1:0] full_vec;

  assign top = prio_pick(active);

  for (genvar g = 0; g < LVLS; g++) begin : g_lvl
    logic [DEPTH_W-1:0] d_q;
    logic inc, dec;
    assign inc = take && (take_lvl == LW'(g));
    assign dec = ret_strobe && (top == (LW+1)'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             d_q <= '0;
      else if (inc && !dec)   d_q <= d_q + 1'b1;
      else if (dec && !inc)   d_q <= d_q - 1'b1;
    end
    assign active[g]   = |d_q;
    assign full_vec[g] = &d_q;
  end

  assign top_full = top[LW] ? 1'b0 : full_vec[top[LW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        hold <= 1'b0;
    else if (take)                     hold <= 1'b1;
    else if (ret_saved || ret_strobe)  hold <= 1'b0;
  end
endmodule

// File: rtl/evt_vec_table.sv
module evt_vec_table
  import evt_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [LW-1:0]     wr_lvl,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LW-1:0]     rd_lvl,
  output logic [ADDR_W-1:0] rd_addr
);
  logic [LVLS-1:0][ADDR_W-1:0] tbl;

  for (genvar g = 0; g < LVLS; g++) begin : g_ent
    logic [ADDR_W-1:0] ent_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         ent_q <= '0;
      else if (we && wr_lvl == LW'(g))    ent_q <= wr_addr;
    end
    assign tbl[g] = ent_q;
  end

  assign rd_addr = tbl[rd_lvl];
endmodule

// File: rtl/evt_ctrl_top.sv
module evt_ctrl_top
  import evt_pkg::*;
#(
  parameter int NUM_SRC = 12,
  parameter int ADDR_W  = 16,
  parameter int DEPTH_W = 2,
  localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic [6:0]         core_req,
  input  logic [1:0]         swi_raise,
  input  logic               map_we,
  input  logic [SRC_W-1:0]   map_sel,
  input  logic [3:0]         map_lvl,
  input  logic               mask_we,
  input  logic [15:0]        mask_val,
  input  logic               tbl_we,
  input  logic [3:0]         tbl_lvl,
  input  logic [ADDR_W-1:0]  tbl_addr,
  input  logic               self_nest_en,
  output logic               evt_valid,
  input  logic               evt_ready,
  output logic [3:0]         evt_level,
  output logic [ADDR_W-1:0]  evt_addr,
  input  logic               ret_strobe,
  input  logic               ret_saved,
  output logic [15:0]        active_lvls,
  output logic               preempt_hold
);
  logic [LVLS-1:0] map_req, raise_vec;
  logic [LW:0]     best, top;
  logic            top_full, take, hold;

  evt_src_map #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_map (
    .clk, .rst_n, .map_we, .map_sel, .map_lvl, .src_req, .lvl_req(map_req)
  );

  assign raise_vec = map_req | {swi_raise, 7'b0, core_req};

  evt_pend_arb u_arb (
    .clk, .rst_n, .raise(raise_vec), .mask_we, .mask_val,
    .clr_en(take), .clr_lvl(best[LW-1:0]), .best
  );

  evt_nest_track #(.DEPTH_W(DEPTH_W)) u_nest (
    .clk, .rst_n, .take, .take_lvl(best[LW-1:0]), .ret_strobe, .ret_saved,
    .active(active_lvls), .top, .top_full, .hold
  );

  evt_vec_table #(.ADDR_W(ADDR_W)) u_tbl (
    .clk, .rst_n, .we(tbl_we), .wr_lvl(tbl_lvl), .wr_addr(tbl_addr),
    .rd_lvl(best[LW-1:0]), .rd_addr(evt_addr)
  );

  assign evt_valid    = !best[LW] && !hold &&
                        ((best < top) || (best == top && self_nest_en && !top_full));
  assign evt_level    = best[LW-1:0];
  assign take         = evt_valid && evt_ready;
  assign preempt_hold = hold;
endmodule

// File: rtl/evt_ctrl_chk.sv
module evt_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        evt_valid,
  input logic        evt_ready,
  input logic [3:0]  evt_level,
  input logic        self_nest_en,
  input logic        ret_strobe,
  input logic        ret_saved,
  input logic [15:0] active_lvls,
  input logic        preempt_hold
);
  a_r6_hold_blocks_offer: assert property (@(posedge clk) disable iff (!rst_n)
    preempt_hold |-> !evt_valid);

  a_r6_take_starts_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_ready) |=> preempt_hold);

  a_r5_take_marks_active: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_ready) |=> active_lvls[$past(evt_level)]);

  a_r7_none_more_urgent_active: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> ((active_lvls & ((16'd1 << evt_level) - 16'd1)) == 16'd0));

  a_r7_same_level_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && active_lvls[evt_level]) |-> self_nest_en);

  a_r8_idle_return_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (active_lvls == 16'd0 && ret_strobe && !(evt_valid && evt_ready)) |=> active_lvls == 16'd0);

  a_r6_saved_ends_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_saved && !(evt_valid && evt_ready)) |=> !preempt_hold);
endmodule

bind evt_ctrl_top evt_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
  .evt_level(evt_level), .self_nest_en(self_nest_en), .ret_strobe(ret_strobe),
  .ret_saved(ret_saved), .active_lvls(active_lvls), .preempt_hold(preempt_hold)
);

// File: tb/evt_ctrl_top_tb.sv
`timescale 1ns/1ps
module evt_ctrl_top_tb;
  localparam int NUM_SRC = 12;
  localparam int ADDR_W  = 16;
  localparam int SRC_W   = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NUM_SRC-1:0] src_req = '0;
  logic [6:0]  core_req = '0;
  logic [1:0]  swi_raise = '0;
  logic        map_we = 1'b0, mask_we = 1'b0, tbl_we = 1'b0;
  logic [SRC_W-1:0] map_sel = '0;
  logic [3:0]  map_lvl = '0, tbl_lvl = '0;
  logic [15:0] mask_val = '0;
  logic [ADDR_W-1:0] tbl_addr = '0;
  logic        self_nest_en = 1'b0, evt_ready = 1'b0, ret_strobe = 1'b0, ret_saved = 1'b0;
  logic        evt_valid, preempt_hold;
  logic [3:0]  evt_level;
  logic [ADDR_W-1:0] evt_addr;
  logic [15:0] active_lvls;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  evt_ctrl_top #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_dut (.*);

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] exp_addr(input int l);
    return ADDR_W'(16'hA000 + l * 16 + 3);
  endfunction

  task automatic set_req(input int l, input logic v);
    if (l < 7) core_req[l] = v;
    else src_req[l-7] = v;
  endtask

  task automatic raise1(input int l);
    set_req(l, 1'b1); tick(); set_req(l, 1'b0);
  endtask

  task automatic do_ack();   evt_ready = 1'b1;  tick(); evt_ready = 1'b0;  endtask
  task automatic do_saved(); ret_saved = 1'b1;  tick(); ret_saved = 1'b0;  endtask
  task automatic do_ret();   ret_strobe = 1'b1; tick(); ret_strobe = 1'b0; endtask

  task automatic offer_is(input string tag, input int l);
    chk({tag, " valid"}, 32'(evt_valid), 32'd1);
    chk({tag, " level"}, 32'(evt_level), 32'(l));
  endtask

  task automatic service(input string tag, input int l);
    offer_is(tag, l);
    do_ack(); do_saved(); do_ret();
  endtask

  task automatic write_mask(input logic [15:0] m);
    mask_we = 1'b1; mask_val = m; tick(); mask_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R10 reset state
    chk("R10 valid", 32'(evt_valid), 0);
    chk("R10 active", 32'(active_lvls), 0);
    chk("R10 hold", 32'(preempt_hold), 0);

    // R4: reset mask blocks a maskable level
    raise1(9);
    chk("R4 reset mask", 32'(evt_valid), 0);
    for (int l = 0; l < 16; l++) begin
      tbl_we = 1'b1; tbl_lvl = 4'(l); tbl_addr = exp_addr(l); tick();
    end
    tbl_we = 1'b0;
    write_mask(16'hFFFF);
    service("R4 unmask keeps pending", 9);

    // R1/R3/R5/R6/R8 single-level sweep
    for (int l = 0; l < 16; l++) begin
      raise1(l);
      offer_is("R1 single", l);
      chk("R3 addr", 32'(evt_addr), 32'(exp_addr(l)));
      do_ack();
      chk("R6 hold set", 32'(preempt_hold), 1);
      chk("R5 active", 32'(active_lvls), 32'(16'd1 << l));
      chk("R6 no offer in hold", 32'(evt_valid), 0);
      do_saved();
      chk("R6 hold cleared", 32'(preempt_hold), 0);
      do_ret();
      chk("R8 return clears", 32'(active_lvls), 0);
      chk("R5 pending cleared", 32'(evt_valid), 0);
    end

    // R1/R7 all pairs
    for (int i = 0; i < 15; i++) begin
      for (int j = i + 1; j < 16; j++) begin
        set_req(i, 1'b1); set_req(j, 1'b1); tick(); set_req(i, 1'b0); set_req(j, 1'b0);
        offer_is("R1 pair", i);
        do_ack(); do_saved();
        chk("R7 lower waits", 32'(evt_valid), 0);
        do_ret();
        service("R7 after return", j);
        chk("R8 pair idle", 32'(active_lvls), 0);
      end
    end

    // R6 preemption held until saved
    raise1(12); do_ack();
    raise1(3);
    chk("R6 urgent held", 32'(evt_valid), 0);
    do_saved();
    offer_is("R6 preempt after saved", 3);
    do_ack(); do_saved();
    chk("R7 nested active", 32'(active_lvls), 32'((16'd1 << 3) | (16'd1 << 12)));
    do_ret();
    chk("R8 inner return", 32'(active_lvls), 32'(16'd1 << 12));
    do_ret();
    chk("R8 outer return", 32'(active_lvls), 0);

    // R7 self-nesting with depth limit
    raise1(9); do_ack(); do_saved();
    raise1(9);
    chk("R7 same level blocked", 32'(evt_valid), 0);
    self_nest_en = 1'b1; tick();
    offer_is("R7 self nest", 9);
    do_ack(); do_saved();
    raise1(9); do_ack(); do_saved();
    raise1(9);
    chk("R7 depth full", 32'(evt_valid), 0);
    do_ret();
    offer_is("R8 depth drop", 9);
    chk("R8 still active", 32'(active_lvls), 32'(16'd1 << 9));
    self_nest_en = 1'b0; tick();
    chk("R7 disabled again", 32'(evt_valid), 0);
    do_ret();
    chk("R8 depth one", 32'(active_lvls), 32'(16'd1 << 9));
    do_ret();
    chk("R8 depth zero", 32'(active_lvls), 0);
    service("R7 pending after unwind", 9);

    // R4 mask and unmaskable levels
    write_mask(16'h0000);
    raise1(5);
    chk("R4 masked", 32'(evt_valid), 0);
    raise1(1);
    service("R4 reset level", 1);
    raise1(2);
    service("R4 nmi level", 2);
    chk("R4 still masked", 32'(evt_valid), 0);
    write_mask(16'hFFFF);
    service("R4 kept pending", 5);

    // R9 software raise
    swi_raise = 2'b01; tick(); swi_raise = 2'b00;
    service("R9 swi0", 14);
    swi_raise = 2'b11; tick(); swi_raise = 2'b00;
    service("R9 both first", 14);
    service("R9 swi1", 15);

    // R11 ready without valid; R8 idle return
    evt_ready = 1'b1; tick(); evt_ready = 1'b0;
    chk("R11 active", 32'(active_lvls), 0);
    chk("R11 hold", 32'(preempt_hold), 0);
    do_ret();
    chk("R8 idle return", 32'(active_lvls), 0);

    // R2 remap, clamp and sharing
    map_we = 1'b1; map_sel = 4'd9;  map_lvl = 4'd11; tick();
    map_sel = 4'd10; map_lvl = 4'd3;  tick();
    map_sel = 4'd11; map_lvl = 4'd11; tick();
    map_we = 1'b0;
    src_req[10] = 1'b1; tick(); src_req[10] = 1'b0;
    service("R2 clamp", 7);
    src_req[9] = 1'b1; src_req[11] = 1'b1; tick(); src_req = '0;
    service("R2 shared", 11);
    chk("R2 shared single pend", 32'(evt_valid), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule